// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block holds the host-visible control registers of one bus-master storage DMA channel: a command byte, a status byte and a 32-bit descriptor-table base address. The host reaches them through a small byte-addressed port that allows 1, 2 or 4 byte accesses at any byte offset inside an 8-byte window. On the other side the block tells a descriptor walker when to begin and when to abandon a transfer, which direction to move data in, and which descriptor it is currently on. It also keeps that descriptor pointer itself: the walker steps it forward, and a new start reloads it from the base register.

The drive's interrupt line is passed straight through to the host. Each rising edge of that line also latches an interrupt flag in status. The walker reports completion and faults on single-cycle inputs. The host clears the error and interrupt flags by writing ones to them.

Top module: `bm_dma_regs`

## Requirements
- R1: After a synchronous active-low reset, every byte of the window reads 0, `tbl_ptr` is 0, and `walk_go`, `walk_stop` and `walk_dir` are 0.
- R2: The command byte sits at offset 0. Only bit 0 (start) and bit 3 (direction) are stored, so a read returns the written byte ANDed with 0x09. `walk_dir` follows the stored bit 3.
- R3: A command write that changes start from 0 to 1 loads `tbl_ptr` from the base register. If the channel is idle, it also sets status bit 0 (active) and raises `walk_go` for exactly one cycle, in the cycle after the write.
- R4: A command write whose start bit equals the stored start bit produces no `walk_go` or `walk_stop` pulse and does not reload `tbl_ptr`.
- R5: A command write that changes start from 1 to 0 clears status bit 0 and raises `walk_stop` for one cycle, in the cycle after the write.
- R6: The base register occupies offsets 4 to 7, least significant byte at offset 4. A write of 1, 2 or 4 bytes updates only the addressed bytes, and bits 1:0 always read 0.
- R7: A read returns the window bytes starting at the offset, shifted down to bit 0 and masked to the access width (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R8: `host_irq` equals `drv_irq` in the same cycle. A rising edge of `drv_irq` sets status bit 2 (interrupt). A falling edge leaves status unchanged.
- R9: The status byte sits at offset 2. Writing 1 clears bit 1 (error) or bit 2 (interrupt), and writing 0 leaves them unchanged. Bit 0 ignores writes. When a set and a clear of the same flag happen in one cycle, the set wins.
- R10: A `walk_err` pulse sets status bit 1. A `walk_done` pulse clears status bit 0. Each `walk_adv` pulse adds 8 to `tbl_ptr`.
- R11: Offsets 1 and 3 read as 0, and writes to them change nothing.
- R12: Reset in the middle of an active transfer clears command, status, base and `tbl_ptr`, leaving the channel idle. A following start behaves as a fresh 0-to-1 change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 3 | Byte offset within the window |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| acc_wdata | input | 32 | Write data, first byte in bits 7:0 |
| acc_rdata | output | 32 | Read data, combinational, 0 when not reading |
| drv_irq | input | 1 | Interrupt line from the drive |
| host_irq | output | 1 | Interrupt line to the host |
| walk_go | output | 1 | One-cycle request for the walker to begin |
| walk_stop | output | 1 | One-cycle request for the walker to abandon |
| walk_dir | output | 1 | Stored direction bit |
| tbl_ptr | output | 32 | Current descriptor address |
| walk_adv | input | 1 | Walker consumed a descriptor |
| walk_done | input | 1 | Walker finished the transfer |
| walk_err | input | 1 | Walker hit a fault |

## Verification
The hardest case to reach from the ports is a cycle in which a flag is both set and cleared. In that cycle the bench raises `drv_irq` and writes a one to the interrupt bit on the same clock edge, then reads status to confirm that the set won. A second hard case is a start rewrite while the channel is still running. The bench first steps `tbl_ptr` with `walk_adv` so that the pointer no longer matches the base, then rewrites start as 1 and checks that the pointer is not reloaded and that no pulse appears.

// File: rtl/bmr_pkg.sv
// Shared constants for the bus-master DMA register set.
// Assumes an 8-byte host window with byte lanes numbered from 0.
package bmr_pkg;
    localparam int LANES      = 8;
    localparam int LANE_CMD   = 0;
    localparam int LANE_STS   = 2;
    localparam int LANE_BASE  = 4;
    localparam int CMD_START  = 0;
    localparam int CMD_DIR    = 3;
    localparam int STS_ACTIVE = 0;
    localparam int STS_ERR    = 1;
    localparam int STS_INT    = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/bmr_lane_decode.sv
// Byte-lane decoder for the host window.
// Turns offset and size into per-lane write enables and write bytes, and
// assembles read data from the lane image. Assumes at most 4 bytes per access;
// lanes past the end of the window are dropped.
module bmr_lane_decode
    import bmr_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [2:0]              acc_off,
    input  logic [1:0]              acc_size,
    input  logic [31:0]             acc_wdata,
    input  logic [NLANES-1:0][7:0]  lane_map,
    output logic [NLANES-1:0]       lane_we,
    output logic [NLANES-1:0][7:0]  lane_wd,
    output logic [31:0]             acc_rdata
);
    logic [3:0] nbytes;
    logic [3:0] off_ext;

    // Purpose: byte count of the access.
    always_comb begin
        case (acc_size)
            SZ_BYTE: nbytes = 4'd1;
            SZ_HALF: nbytes = 4'd2;
            default: nbytes = 4'd4;
        endcase
    end

    assign off_ext = {1'b0, acc_off};

    for (genvar l = 0; l < NLANES; l++) begin : g_wlane
        localparam logic [3:0] LIDX = 4'(l);
        logic [3:0] rel;
        assign rel        = LIDX - off_ext;
        assign lane_we[l] = acc_valid && acc_write && (LIDX >= off_ext) && (rel < nbytes);
        assign lane_wd[l] = acc_wdata[{rel[1:0], 3'b000} +: 8];
    end

    for (genvar k = 0; k < 4; k++) begin : g_rbyte
        logic [3:0] idx;
        assign idx = off_ext + 4'(k);
        // Purpose: pick one read byte, zero past the width or the window.
        always_comb begin
            acc_rdata[8*k +: 8] = 8'h00;
            if (acc_valid && !acc_write && (4'(k) < nbytes) && (idx < 4'(NLANES)))
                acc_rdata[8*k +: 8] = lane_map[idx[2:0]];
        end
    end
endmodule

// File: rtl/bmr_base_reg.sv
// Descriptor-table base register written by byte lanes.
// Each byte updates only when its own lane enable is set; bits 1:0 are
// stored as zero so the base is always 4-byte aligned.
module bmr_base_reg
    import bmr_pkg::*;
#(
    parameter int NLANES    = LANES,
    parameter int ADDR_W    = 32,
    parameter int FIRST_LN  = LANE_BASE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLANES-1:0]       lane_we,
    input  logic [NLANES-1:0][7:0]  lane_wd,
    output logic [ADDR_W-1:0]       base_q
);
    localparam int NBYTES = ADDR_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam logic [7:0] KEEP = (b == 0) ? 8'hFC : 8'hFF;
        // Purpose: hold one base byte, aligned in byte 0.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[8*b +: 8] <= 8'h00;
            else if (lane_we[FIRST_LN + b])
                base_q[8*b +: 8] <= lane_wd[FIRST_LN + b] & KEEP;
        end
    end
endmodule

// File: rtl/bmr_chan_ctrl.sv
// Command, status and descriptor-pointer state of one channel.
// Start acts only on a change of its value. Walker requests are registered
// one-cycle pulses. The interrupt flag is set on a rising drive interrupt;
// error and interrupt flags clear by writing one, and a set beats a clear.
module bmr_chan_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              cmd_start_wd,
    input  logic              cmd_dir_wd,
    input  logic              sts_we,
    input  logic              sts_clr_err,
    input  logic              sts_clr_int,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              walk_adv,
    input  logic              walk_done,
    input  logic              walk_err,
    input  logic              drv_irq,
    output logic              start_q,
    output logic              dir_q,
    output logic              active_q,
    output logic              err_q,
    output logic              int_q,
    output logic [ADDR_W-1:0] tbl_ptr,
    output logic              walk_go,
    output logic              walk_stop
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    logic start_rise;
    logic start_fall;
    logic irq_prev;
    logic irq_rise;

    assign start_rise = cmd_we &&  cmd_start_wd && !start_q;
    assign start_fall = cmd_we && !cmd_start_wd &&  start_q;
    assign irq_rise   = drv_irq && !irq_prev;

    // Purpose: store the two kept command bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            dir_q   <= 1'b0;
        end else if (cmd_we) begin
            start_q <= cmd_start_wd;
            dir_q   <= cmd_dir_wd;
        end
    end

    // Purpose: active flag, set by a start change, cleared by stop or done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (start_rise)
            active_q <= 1'b1;
        else if (start_fall || walk_done)
            active_q <= 1'b0;
    end

    // Purpose: one-cycle requests to the walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_go   <= 1'b0;
            walk_stop <= 1'b0;
        end else begin
            walk_go   <= start_rise && !active_q;
            walk_stop <= start_fall;
        end
    end

    // Purpose: descriptor pointer, reloaded on start, stepped by the walker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_ptr <= '0;
        else if (start_rise)
            tbl_ptr <= base_q;
        else if (walk_adv)
            tbl_ptr <= tbl_ptr + STEP;
    end

    // Purpose: error flag, set by the walker, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (walk_err)
            err_q <= 1'b1;
        else if (sts_we && sts_clr_err)
            err_q <= 1'b0;
    end

    // Purpose: previous drive interrupt level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_prev <= 1'b0;
        else
            irq_prev <= drv_irq;
    end

    // Purpose: interrupt flag, set on a rising drive interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_q <= 1'b0;
        else if (irq_rise)
            int_q <= 1'b1;
        else if (sts_we && sts_clr_int)
            int_q <= 1'b0;
    end
endmodule

// File: rtl/bm_dma_regs.sv
// Top of the bus-master DMA channel register set.
// Joins the lane decoder, base register and channel control, builds the
// 8-byte read image and passes the drive interrupt straight to the host.
module bm_dma_regs
    import bmr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [2:0]        acc_off,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              drv_irq,
    output logic              host_irq,
    output logic              walk_go,
    output logic              walk_stop,
    output logic              walk_dir,
    output logic [ADDR_W-1:0] tbl_ptr,
    input  logic              walk_adv,
    input  logic              walk_done,
    input  logic              walk_err
);
    logic [LANES-1:0]      lane_we;
    logic [LANES-1:0][7:0] lane_wd;
    logic [LANES-1:0][7:0] lane_map;
    logic [ADDR_W-1:0]     base_q;
    logic start_q, dir_q, active_q, err_q, int_q;
    logic unused_lanes;

    bmr_lane_decode #(.NLANES(LANES)) i_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_off   (acc_off),
        .acc_size  (acc_size),
        .acc_wdata (acc_wdata),
        .lane_map  (lane_map),
        .lane_we   (lane_we),
        .lane_wd   (lane_wd),
        .acc_rdata (acc_rdata)
    );

    bmr_base_reg #(.NLANES(LANES), .ADDR_W(ADDR_W), .FIRST_LN(LANE_BASE)) i_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .lane_wd (lane_wd),
        .base_q  (base_q)
    );

    bmr_chan_ctrl #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (lane_we[LANE_CMD]),
        .cmd_start_wd (lane_wd[LANE_CMD][CMD_START]),
        .cmd_dir_wd   (lane_wd[LANE_CMD][CMD_DIR]),
        .sts_we       (lane_we[LANE_STS]),
        .sts_clr_err  (lane_wd[LANE_STS][STS_ERR]),
        .sts_clr_int  (lane_wd[LANE_STS][STS_INT]),
        .base_q       (base_q),
        .walk_adv     (walk_adv),
        .walk_done    (walk_done),
        .walk_err     (walk_err),
        .drv_irq      (drv_irq),
        .start_q      (start_q),
        .dir_q        (dir_q),
        .active_q     (active_q),
        .err_q        (err_q),
        .int_q        (int_q),
        .tbl_ptr      (tbl_ptr),
        .walk_go      (walk_go),
        .walk_stop    (walk_stop)
    );

    // Purpose: assemble the read image of the window.
    always_comb begin
        lane_map = '0;
        lane_map[LANE_CMD][CMD_START]  = start_q;
        lane_map[LANE_CMD][CMD_DIR]    = dir_q;
        lane_map[LANE_STS][STS_ACTIVE] = active_q;
        lane_map[LANE_STS][STS_ERR]    = err_q;
        lane_map[LANE_STS][STS_INT]    = int_q;
        for (int b = 0; b < ADDR_W / 8; b++)
            lane_map[LANE_BASE + b] = base_q[8*b +: 8];
    end

    assign host_irq = drv_irq;
    assign walk_dir = dir_q;

    assign unused_lanes = ^{lane_we[1], lane_we[3], lane_wd[1], lane_wd[3],
                            lane_wd[LANE_CMD][7:4], lane_wd[LANE_CMD][2:1],
                            lane_wd[LANE_STS][7:3], lane_wd[LANE_STS][0]};
endmodule

// File: rtl/bm_dma_regs_chk.sv
// Property checker for the register set, attached with bind.
// Observes walker pulses, the pointer, the command and status flags.
module bm_dma_regs_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              walk_go,
    input logic              walk_stop,
    input logic [ADDR_W-1:0] tbl_ptr,
    input logic [ADDR_W-1:0] base_q,
    input logic              active_q,
    input logic              start_q,
    input logic              drv_irq,
    input logic              int_q
);
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_go |=> !walk_go); // R3
    AST_GO_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_go |-> (active_q && tbl_ptr == base_q)); // R3
    AST_GO_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({walk_go, walk_stop})); // R4
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_stop |-> (!active_q && !start_q)); // R5
    AST_ACTIVE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> start_q); // R5
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_ptr[1:0] == 2'b00); // R6
    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_irq) |=> int_q); // R8
endmodule

bind bm_dma_regs bm_dma_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .walk_go   (walk_go),
    .walk_stop (walk_stop),
    .tbl_ptr   (tbl_ptr),
    .base_q    (base_q),
    .active_q  (active_q),
    .start_q   (start_q),
    .drv_irq   (drv_irq),
    .int_q     (int_q)
);

// File: tb/test_bm_dma_regs.sv
`timescale 1ns/1ps
// Directed bench for the bus-master DMA register set.
module test_bm_dma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_off = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        drv_irq = 1'b0;
    logic        host_irq;
    logic        walk_go, walk_stop, walk_dir;
    logic [31:0] tbl_ptr;
    logic        walk_adv = 1'b0;
    logic        walk_done = 1'b0;
    logic        walk_err = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bm_dma_regs i_bm_dma_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_off(acc_off),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .drv_irq(drv_irq), .host_irq(host_irq),
        .walk_go(walk_go), .walk_stop(walk_stop), .walk_dir(walk_dir),
        .tbl_ptr(tbl_ptr), .walk_adv(walk_adv), .walk_done(walk_done),
        .walk_err(walk_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_off = off; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_off = off; acc_size = sz;
        #1;
        chk(tag, acc_rdata, exp);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_adv();
        @(negedge clk); walk_adv = 1'b1;
        @(negedge clk); walk_adv = 1'b0;
    endtask

    task automatic t_reset();
        rd(3'd0, 2'd2, 32'h0, "R1 low word");
        rd(3'd4, 2'd2, 32'h0, "R1 base");
        chk("R1 tbl_ptr", tbl_ptr, 32'h0);
        chk("R1 walker outs", {29'd0, walk_go, walk_stop, walk_dir}, 32'h0);
    endtask

    task automatic t_cmd_mask();
        wr(3'd0, 2'd0, 32'hFE);
        rd(3'd0, 2'd0, 32'h08, "R2 cmd mask");
        chk("R2 walk_dir", {31'd0, walk_dir}, 32'h1);
        rd(3'd2, 2'd0, 32'h00, "R2 no start");
        wr(3'd0, 2'd0, 32'h00);
    endtask

    task automatic t_base();
        wr(3'd4, 2'd2, 32'h12345677);
        rd(3'd4, 2'd2, 32'h12345674, "R6 word write aligned");
        wr(3'd5, 2'd0, 32'h000000AB);
        rd(3'd4, 2'd2, 32'h1234AB74, "R6 byte lane 5");
        wr(3'd6, 2'd1, 32'h0000CDEF);
        rd(3'd4, 2'd2, 32'hCDEFAB74, "R6 half lanes 6-7");
        wr(3'd4, 2'd0, 32'h000000FF);
        rd(3'd4, 2'd2, 32'hCDEFABFC, "R6 low bits zero");
        rd(3'd5, 2'd1, 32'h0000EFAB, "R7 half at 5");
        rd(3'd7, 2'd0, 32'h000000CD, "R7 byte at 7");
        rd(3'd6, 2'd2, 32'h0000CDEF, "R7 word past end");
    endtask

    task automatic t_start();
        wr(3'd0, 2'd0, 32'h01);
        chk("R3 walk_go pulse", {31'd0, walk_go}, 32'h1);
        chk("R3 ptr reload", tbl_ptr, 32'hCDEFABFC);
        rd(3'd2, 2'd0, 32'h01, "R3 active set");
        chk("R3 walk_go one cycle", {31'd0, walk_go}, 32'h0);
    endtask

    task automatic t_same();
        pulse_adv();
        chk("R10 ptr step", tbl_ptr, 32'hCDEFAC04);
        wr(3'd0, 2'd0, 32'h09);
        chk("R4 no go on same start", {30'd0, walk_go, walk_stop}, 32'h0);
        chk("R4 no reload", tbl_ptr, 32'hCDEFAC04);
        rd(3'd0, 2'd0, 32'h09, "R4 dir updated");
    endtask

    task automatic t_stop();
        wr(3'd0, 2'd0, 32'h08);
        chk("R5 walk_stop pulse", {31'd0, walk_stop}, 32'h1);
        rd(3'd2, 2'd0, 32'h00, "R5 active clear");
        wr(3'd0, 2'd0, 32'h00);
        chk("R4 no stop on same", {30'd0, walk_go, walk_stop}, 32'h0);
    endtask

    task automatic t_irq();
        @(negedge clk); drv_irq = 1'b1; #1;
        chk("R8 pass high", {31'd0, host_irq}, 32'h1);
        rd(3'd2, 2'd0, 32'h04, "R8 int set");
        @(negedge clk); drv_irq = 1'b0; #1;
        chk("R8 pass low", {31'd0, host_irq}, 32'h0);
        rd(3'd2, 2'd0, 32'h04, "R8 fall keeps int");
        wr(3'd2, 2'd0, 32'h04);
        rd(3'd2, 2'd0, 32'h00, "R9 int w1c");
        wr(3'd0, 2'd0, 32'h01);
        wr(3'd2, 2'd0, 32'hFF);
        rd(3'd2, 2'd0, 32'h01, "R9 active not writable");
        @(negedge clk);
        drv_irq = 1'b1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_off = 3'd2; acc_size = 2'd0; acc_wdata = 32'h04;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        rd(3'd2, 2'd0, 32'h05, "R9 set beats clear");
        drv_irq = 1'b0;
    endtask

    task automatic t_walker();
        @(negedge clk); walk_err = 1'b1;
        @(negedge clk); walk_err = 1'b0;
        rd(3'd2, 2'd0, 32'h07, "R10 err set");
        wr(3'd2, 2'd0, 32'h04);
        rd(3'd2, 2'd0, 32'h03, "R9 int clear only");
        @(negedge clk); walk_done = 1'b1;
        @(negedge clk); walk_done = 1'b0;
        rd(3'd2, 2'd0, 32'h02, "R10 done clears active");
        wr(3'd2, 2'd0, 32'h02);
        rd(3'd2, 2'd0, 32'h00, "R9 err w1c");
    endtask

    task automatic t_unmapped();
        wr(3'd1, 2'd0, 32'hFF);
        wr(3'd3, 2'd0, 32'hFF);
        rd(3'd0, 2'd2, 32'h00000001, "R11 holes zero");
        rd(3'd1, 2'd0, 32'h0, "R11 offset 1");
        wr(3'd0, 2'd1, 32'h0000FF01);
        chk("R11 no pulse", {30'd0, walk_go, walk_stop}, 32'h0);
        rd(3'd0, 2'd1, 32'h0001, "R11 lane 1 ignored");
    endtask

    task automatic t_reset_mid();
        wr(3'd0, 2'd0, 32'h00);
        wr(3'd0, 2'd0, 32'h09);
        @(negedge clk); drv_irq = 1'b1;
        @(negedge clk); drv_irq = 1'b0;
        rd(3'd2, 2'd0, 32'h05, "R12 pre-reset state");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(3'd0, 2'd2, 32'h0, "R12 cmd status cleared");
        rd(3'd4, 2'd2, 32'h0, "R12 base cleared");
        chk("R12 ptr cleared", tbl_ptr, 32'h0);
        chk("R12 dir cleared", {31'd0, walk_dir}, 32'h0);
        wr(3'd0, 2'd0, 32'h01);
        chk("R12 fresh start", {31'd0, walk_go}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd_mask();
        t_base();
        t_start();
        t_same();
        t_stop();
        t_irq();
        t_walker();
        t_unmapped();
        t_reset_mid();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule